// File: doc/BRIEF.md
# Two-Width Arithmetic/Logic Unit with Packed Status Word

This block is the integer datapath of a small processor core. Each clock it accepts two operands, an operation code, a width select and the current 16-bit status word. One cycle later it presents the registered result and a new status word. The status word holds condition bits that the operation sets, control bits that the operation passes through unchanged, and reserved positions held at fixed values.

The eight operations are add, add with carry-in, subtract, subtract with borrow-in, bitwise AND, OR, XOR and compare. Compare sets the condition bits exactly as subtract would. It leaves the result register untouched, so a following instruction still sees the last real result. In byte mode only the low eight bits of each operand take part, and every condition bit is taken at the byte's width.

Top module: `aflu_core`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare. Add returns a+b and add with carry returns a+b+flags_i[0], modulo the selected width. Outputs are registered and appear one clock after the inputs are sampled.
- R2: Subtract returns a-b and subtract with borrow returns a-b-flags_i[0], modulo the selected width. Plain add and plain subtract ignore flags_i[0].
- R3: AND, OR and XOR return the bitwise result. They clear status bit 0 (carry), bit 11 (overflow) and bit 4 (nibble carry).
- R4: Compare updates the status word exactly as subtract would, while `result_o` keeps its previous value.
- R5: With `byte_i` high, only bits 7:0 of the operands are used, bits 15:8 of the result are zero, and all condition bits refer to the 8-bit width.
- R6: Status bit 0 is the carry out of the most significant bit of the selected width for add operations, and the borrow for subtract and compare.
- R7: Status bit 2 is 1 when bits 7:0 of the computed value hold an even number of ones, in both widths.
- R8: Status bit 4 is the carry out of bit 3 for add operations, and the borrow out of bit 3 for subtract and compare.
- R9: Status bit 6 is 1 when the computed value is zero at the selected width. Status bit 7 equals that value's most significant bit.
- R10: Status bit 11 is 1 when an add or subtract gives signed overflow at the selected width.
- R11: Status bits 10:8 are copied unchanged from `flags_i[10:8]`.
- R12: Status bits 1 and 15:12 always read 1. Bits 3 and 5 always read 0.
- R13: While `rst` is high at a clock edge, `result_o` becomes 0 and `flags_o` becomes 16'hF002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| byte_i | input | 1 | 1 selects 8-bit width, 0 selects 16-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flags_i | input | 16 | Current status word; supplies carry-in and control bits |
| result_o | output | 16 | Registered result |
| flags_o | output | 16 | Registered new status word |

## Verification
The bench sweeps every operation with both carry-in values, in both widths, over a grid of operands. The grid holds the sign-boundary values (0, 1, 7F/80, FF, 7FFF/8000, FFFF) and values with the nibble boundary in the middle, plus scattered fillers. The boundary pairs separate carry from overflow and borrow from nibble borrow. They also expose a sign bit or zero test taken at the wrong width.

In byte mode the upper operand bytes carry noise, which exposes any leak from bits 15:8. The control bits of the incoming status word rotate through all values, which shows that they pass straight through. Each compare's result is checked against the last non-compare result, which shows that the result register holds.

// File: rtl/aflu_pkg.sv
package aflu_pkg;

    localparam int unsigned DW = 16;
    localparam int unsigned HW = DW / 2;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } op_e;

    // status word bit positions
    localparam int unsigned B_CARRY = 0;
    localparam int unsigned B_PAR   = 2;
    localparam int unsigned B_NIB   = 4;
    localparam int unsigned B_ZERO  = 6;
    localparam int unsigned B_SIGN  = 7;
    localparam int unsigned B_CTLLO = 8;
    localparam int unsigned B_CTLHI = 10;
    localparam int unsigned B_OVF   = 11;

    // reserved bits: ones where set, zeros elsewhere among reserved
    localparam logic [DW-1:0] RSV_ONES = 16'hF002;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          carry;
        logic          nib;
        logic          ovf;
    } stat_t;

    function automatic logic op_subtracts(op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    endfunction

    function automatic logic op_chains(op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic op_bitwise(op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic even_ones8(logic [7:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/aflu_arith.sv
module aflu_arith
    import aflu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         narrow,
    output stat_t        st
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   sum_w;
    logic [H:0]   sum_h;
    logic [4:0]   sum_n;

    // one adder serves both directions: a + ~b + ~borrow
    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = cin ^ sub;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum_h = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
        sum_n = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, c0};
    end

    always_comb begin
        st     = '0;
        st.nib = sum_n[4] ^ sub;
        if (narrow) begin
            st.value = {{(W-H){1'b0}}, sum_h[H-1:0]};
            st.carry = sum_h[H] ^ sub;
            st.ovf   = (a[H-1] == b_eff[H-1]) && (sum_h[H-1] != a[H-1]);
        end else begin
            st.value = sum_w[W-1:0];
            st.carry = sum_w[W] ^ sub;
            st.ovf   = (a[W-1] == b_eff[W-1]) && (sum_w[W-1] != a[W-1]);
        end
    end

endmodule

// File: rtl/aflu_logic.sv
module aflu_logic
    import aflu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic         narrow,
    output stat_t        st
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] raw;

    always_comb begin
        unique case (op)
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            default: raw = a ^ b;
        endcase
    end

    // upper half gated per bit when the narrow width is selected
    for (genvar g = 0; g < W; g++) begin : g_gate
        if (g < H) begin : g_lo
            assign st.value[g] = raw[g];
        end else begin : g_hi
            assign st.value[g] = raw[g] & ~narrow;
        end
    end

    assign st.carry = 1'b0;
    assign st.nib   = 1'b0;
    assign st.ovf   = 1'b0;

endmodule

// File: rtl/aflu_pack.sv
module aflu_pack
    import aflu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  stat_t         st,
    input  logic          narrow,
    input  logic [2:0]    ctl,
    output logic [W-1:0]  word
);
    localparam int unsigned H = W / 2;

    logic zero_v;
    logic sign_v;

    always_comb begin
        zero_v = narrow ? (st.value[H-1:0] == '0) : (st.value == '0);
        sign_v = narrow ? st.value[H-1] : st.value[W-1];

        word                   = RSV_ONES;
        word[B_CARRY]          = st.carry;
        word[B_PAR]            = even_ones8(st.value[7:0]);
        word[B_NIB]            = st.nib;
        word[B_ZERO]           = zero_v;
        word[B_SIGN]           = sign_v;
        word[B_CTLHI:B_CTLLO]  = ctl;
        word[B_OVF]            = st.ovf;
    end

endmodule

// File: rtl/aflu_core.sv
module aflu_core
    import aflu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic          byte_i,
    input  logic [15:0]   a_i,
    input  logic [15:0]   b_i,
    input  logic [15:0]   flags_i,
    output logic [15:0]   result_o,
    output logic [15:0]   flags_o
);
    op_e   op;
    stat_t st_arith;
    stat_t st_logic;
    stat_t st_sel;
    logic [DW-1:0] word_next;
    logic  live_q;

    assign op = op_e'(op_i);

    aflu_arith #(.W(DW)) i_arith (
        .a      (a_i),
        .b      (b_i),
        .cin    (op_chains(op) & flags_i[B_CARRY]),
        .sub    (op_subtracts(op)),
        .narrow (byte_i),
        .st     (st_arith)
    );

    aflu_logic #(.W(DW)) i_logic (
        .a      (a_i),
        .b      (b_i),
        .op     (op),
        .narrow (byte_i),
        .st     (st_logic)
    );

    assign st_sel = op_bitwise(op) ? st_logic : st_arith;

    aflu_pack #(.W(DW)) i_pack (
        .st     (st_sel),
        .narrow (byte_i),
        .ctl    (flags_i[B_CTLHI:B_CTLLO]),
        .word   (word_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            flags_o  <= RSV_ONES;
            live_q   <= 1'b0;
        end else begin
            if (op != OP_CMP) begin
                result_o <= st_sel.value;
            end
            flags_o <= word_next;
            live_q  <= 1'b1;
        end
    end

    // bitwise operations leave carry and overflow clear
    p_bitwise_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(op_i) inside {3'd4, 3'd5, 3'd6}))
            |-> (!flags_o[B_CARRY] && !flags_o[B_OVF]));

    // compare keeps the result register
    p_cmp_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_i) == 3'd7) |-> (result_o == $past(result_o)));

    // narrow width leaves the upper result byte empty
    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(byte_i) && $past(op_i) != 3'd7)
            |-> (result_o[15:8] == 8'h00));

    // parity bit agrees with the stored result
    p_parity_r7: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_i) != 3'd7) |-> (flags_o[B_PAR] == ~^result_o[7:0]));

    // zero bit agrees with the stored result
    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_i) != 3'd7) |-> (flags_o[B_ZERO] == (result_o == 16'h0)));

    // control bits pass through
    p_ctl_pass_r11: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (flags_o[10:8] == $past(flags_i[10:8])));

endmodule

// File: tb/test_aflu_core.sv
module test_aflu_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic        byte_i;
    logic [15:0] a_i, b_i, flags_i;
    logic [15:0] result_o, flags_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] last_res;

    always #2.5 clk = ~clk;

    aflu_core i_aflu_core (
        .clk(clk), .rst(rst), .op_i(op_i), .byte_i(byte_i),
        .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] pick8(int i);
        case (i)
            0: return 16'h00; 1: return 16'h7F; 2: return 16'h80; 3: return 16'hFF;
            4: return 16'h01; 5: return 16'h0F; 6: return 16'h10; 7: return 16'hF0;
            default: return 16'((i * 73 + 11) & 255);
        endcase
    endfunction

    function automatic logic [15:0] pick16(int i);
        case (i)
            0: return 16'h0000; 1: return 16'h7FFF; 2: return 16'h8000; 3: return 16'hFFFF;
            4: return 16'h0001; 5: return 16'h000F; 6: return 16'h00FF; 7: return 16'h0010;
            default: return 16'((i * 40503 + 977) & 65535);
        endcase
    endfunction

    task automatic run_one(input logic [2:0] op, input logic nar,
                           input logic [15:0] a, input logic [15:0] b, input logic [15:0] fin);
        logic [15:0] mask, am, bm, res, expf;
        logic [16:0] t;
        logic [4:0]  n;
        logic cin, cf, af, of, sa, sb, sr;
        int msb;
        mask = nar ? 16'h00FF : 16'hFFFF;
        msb  = nar ? 7 : 15;
        am = a & mask;
        bm = b & mask;
        cin = (op == 3'd1 || op == 3'd3) ? fin[0] : 1'b0;
        sa = am[msb]; sb = bm[msb];
        cf = 0; af = 0; of = 0;
        if (op == 3'd0 || op == 3'd1) begin
            t  = {1'b0, am} + {1'b0, bm} + {16'b0, cin};
            n  = {1'b0, am[3:0]} + {1'b0, bm[3:0]} + {4'b0, cin};
            res = t[15:0] & mask;
            cf = nar ? t[8] : t[16];
            af = n[4];
            sr = res[msb];
            of = (sa == sb) && (sr != sa);
        end else if (op == 3'd2 || op == 3'd3 || op == 3'd7) begin
            t  = {1'b0, am} - {1'b0, bm} - {16'b0, cin};
            n  = {1'b0, am[3:0]} - {1'b0, bm[3:0]} - {4'b0, cin};
            res = t[15:0] & mask;
            cf = nar ? t[8] : t[16];
            af = n[4];
            sr = res[msb];
            of = (sa != sb) && (sr != sa);
        end else if (op == 3'd4) begin
            res = am & bm;
        end else if (op == 3'd5) begin
            res = am | bm;
        end else begin
            res = am ^ bm;
        end
        expf = 16'hF002;
        expf[0] = cf;
        expf[2] = ~^res[7:0];
        expf[4] = af;
        expf[6] = (res == 16'h0);
        expf[7] = res[msb];
        expf[10:8] = fin[10:8];
        expf[11] = of;

        @(negedge clk);
        op_i = op; byte_i = nar; a_i = a; b_i = b; flags_i = fin;
        @(negedge clk);
        if (op == 3'd7) begin
            check("R4 result hold", result_o, last_res);
        end else begin
            check(op >= 3'd4 ? "R3 bitwise result" :
                  (op >= 3'd2 ? "R2 subtract result" : "R1 add result"), result_o, res);
            last_res = res;
        end
        if (nar) check("R5 narrow upper byte", {8'h00, result_o[15:8]}, 16'h0000);
        check("R6 carry bit", {15'b0, flags_o[0]}, {15'b0, expf[0]});
        check("R7 parity bit", {15'b0, flags_o[2]}, {15'b0, expf[2]});
        check("R8 nibble bit", {15'b0, flags_o[4]}, {15'b0, expf[4]});
        check("R9 zero/sign bits", {14'b0, flags_o[7:6]}, {14'b0, expf[7:6]});
        check("R10 overflow bit", {15'b0, flags_o[11]}, {15'b0, expf[11]});
        check("R11 control bits", {13'b0, flags_o[10:8]}, {13'b0, expf[10:8]});
        check("R12 reserved bits", flags_o & 16'hF02A, 16'hF002);
    endtask

    initial begin
        #(5 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = '0; byte_i = 0; a_i = 16'h1234; b_i = 16'h4321; flags_i = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 reset result", result_o, 16'h0000);
        check("R13 reset flags", flags_o, 16'hF002);
        rst = 1'b0;
        last_res = 16'h0;
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 8; op++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int i = 0; i < 24; i++) begin
                        for (int j = 0; j < 24; j++) begin
                            logic [15:0] a, b, f;
                            if (w == 1) begin
                                a = pick8(i) | 16'((i * 29 + 5) & 255) << 8;
                                b = pick8(j) | 16'((j * 53 + 3) & 255) << 8;
                            end else begin
                                a = pick16(i);
                                b = pick16(j);
                            end
                            f = 16'h0000;
                            f[0] = c[0];
                            f[10:8] = 3'((i + j + op) & 7);
                            f[15:12] = 4'(j & 15);
                            f[5] = i[0];
                            run_one(3'(op), w[0], a, b, f);
                        end
                    end
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule